// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request interface and an external asynchronous static RAM of 512K bytes. The user side offers one access at a time through a valid/ready handshake that carries a 19-bit address, a write flag and a write byte. The sequencer then produces the chip-select, write-enable and output-enable strobes, the address, and a split data bus (outgoing byte, drive enable, incoming byte). For reads it hands back the captured byte with a one-cycle read-data-valid pulse.

The memory's timing limits are given as parameters in picoseconds, together with the clock period. Each limit is rounded up to whole cycles, and each phase of an access runs for that many cycles on its own down-counter. With the defaults (35 ns memory grade, 50 MHz clock) these are the phases:
- a write is one setup cycle, two cycles with write-enable low and one hold cycle;
- a read is two cycles with output-enable low;
- a write that follows a read first passes through one turnaround cycle.

States are `ST_IDLE`, `ST_TURN`, `ST_W_SETUP`, `ST_W_PULSE`, `ST_W_HOLD`, `ST_R_ACCESS` and `ST_GAP`. The transitions are:
- IDLE to TURN, on a write request when the previous access was a read;
- IDLE to W_SETUP, on any other write request;
- IDLE to R_ACCESS, on a read request;
- TURN to W_SETUP, when the turnaround count expires;
- W_SETUP to W_PULSE, then W_PULSE to W_HOLD, each when its count expires;
- W_HOLD to GAP when the write cycle time still needs padding, otherwise W_HOLD to IDLE;
- R_ACCESS to IDLE, which also captures the read byte;
- GAP to IDLE, when its count expires.

Top module: `sram_seq`

## Requirements
- R1: While reset is high and in the first cycle after it falls, the outputs are: chip-select, write-enable and output-enable high; drive enable low; read-data-valid low. `req_ready` is low during reset and high once it is released.
- R2: Write-enable goes low only while chip-select is low and output-enable is high. At defaults it stays low for exactly 2 consecutive cycles per write.
- R3: At the cycle in which write-enable returns high, the drive enable is high, the address is the requested address and the outgoing byte is the requested byte. The memory therefore stores that byte.
- R4: A read holds chip-select and output-enable low with write-enable high for 2 cycles at defaults. The byte on `mem_dq_in` is captured at the last clock edge of that phase, and `rd_valid` is then high for exactly one cycle with that byte on `rd_data`.
- R5: The drive enable is never high while output-enable is low.
- R6: When a write follows a read, the drive enable rises no earlier than 2 cycles after output-enable rises (one idle cycle plus one turnaround cycle at defaults).
- R7: A request is taken at a rising edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for 4 cycles after a write, 5 cycles after a write that follows a read, and 2 cycles after a read.
- R8: The address stays unchanged for as long as chip-select stays low.
- R9: A new request may be accepted in the same cycle that `rd_valid` is pulsed. Read results still come back in request order and with the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read result |
| rd_data | output | 8 | Read result |
| mem_addr | output | 19 | Memory address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | 8 | Byte driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Byte returned by the memory |

## Verification
Two events can fall in the same cycle: the read-data-valid pulse of a finished read, and the acceptance of the next request. The edge that ends the read access returns the state to idle, and that same edge raises both `rd_valid` and `req_ready`.

The bench provokes this overlap by issuing requests back to back, each one driven as soon as ready is seen. A monitor compares each `rd_valid` byte against a scoreboard queue, while the driver checks how many cycles ready stays low for the newly accepted request.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_W_SETUP,
        ST_W_PULSE,
        ST_W_HOLD,
        ST_R_ACCESS,
        ST_GAP
    } seq_state_e;

    // Round a time in ps up to whole clock cycles
    function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_seq_pkg::*;
#(
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned TA_CYC   = 1,
    parameter int unsigned PWE_CYC  = 2,
    parameter int unsigned HOLD_CYC = 1,
    parameter int unsigned RD_CYC   = 2,
    parameter int unsigned GAP_CYC  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             timer_done,
    output logic             req_ready,
    output logic             accept,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             capture,
    output logic             cs_n,
    output logic             we_n,
    output logic             oe_n,
    output logic             dq_oe
);

    seq_state_e state_q, state_d;
    logic       last_rd_q;

    assign req_ready = (state_q == ST_IDLE) && !rst;
    assign accept    = req_valid && req_ready;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            last_rd_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_R_ACCESS && state_d != ST_R_ACCESS) begin
                last_rd_q <= 1'b1;
            end else if (state_d == ST_W_SETUP) begin
                last_rd_q <= 1'b0;
            end
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!req_write)     state_d = ST_R_ACCESS;
                    else if (last_rd_q) state_d = ST_TURN;
                    else                state_d = ST_W_SETUP;
                end
            end
            ST_TURN:     if (timer_done) state_d = ST_W_SETUP;
            ST_W_SETUP:  if (timer_done) state_d = ST_W_PULSE;
            ST_W_PULSE:  if (timer_done) state_d = ST_W_HOLD;
            ST_W_HOLD:   if (timer_done) state_d = (GAP_CYC > 0) ? ST_GAP : ST_IDLE;
            ST_R_ACCESS: if (timer_done) state_d = ST_IDLE;
            ST_GAP:      if (timer_done) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Phase length for the state being entered
    assign timer_load = (state_d != state_q);
    always_comb begin
        timer_val = '0;
        unique case (state_d)
            ST_TURN:     timer_val = CNT_W'(TA_CYC - 1);
            ST_W_PULSE:  timer_val = CNT_W'(PWE_CYC - 1);
            ST_W_HOLD:   timer_val = CNT_W'(HOLD_CYC - 1);
            ST_R_ACCESS: timer_val = CNT_W'(RD_CYC - 1);
            ST_GAP:      timer_val = (GAP_CYC > 0) ? CNT_W'(GAP_CYC - 1) : '0;
            default:     timer_val = '0;
        endcase
    end

    assign capture = (state_q == ST_R_ACCESS) && (state_d != ST_R_ACCESS);

    // Registered strobes, decoded from the next state so no glitch reaches the pins
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_n  <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
        end else begin
            cs_n  <= !(state_d inside {ST_W_SETUP, ST_W_PULSE, ST_W_HOLD, ST_R_ACCESS});
            we_n  <= !(state_d == ST_W_PULSE);
            oe_n  <= !(state_d == ST_R_ACCESS);
            dq_oe <= (state_d inside {ST_W_SETUP, ST_W_PULSE, ST_W_HOLD});
        end
    end

    AST_WE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!cs_n && oe_n)); // R2
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> oe_n); // R5
    AST_TURN_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (rst)
        $rose(dq_oe) |-> $past(oe_n)); // R6
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready); // R7
    AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> (we_n && !cs_n)); // R4

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end

    AST_RDV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid); // R4

endmodule

// File: rtl/sram_seq.sv
module sram_seq
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W    = 19,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned CLK_PS    = 20000,
    parameter int unsigned T_WC_PS   = 35000,
    parameter int unsigned T_AW_PS   = 30000,
    parameter int unsigned T_PWE_PS  = 25000,
    parameter int unsigned T_SD_PS   = 20000,
    parameter int unsigned T_HOLD_PS = 3000,
    parameter int unsigned T_RC_PS   = 35000,
    parameter int unsigned T_AA_PS   = 35000,
    parameter int unsigned T_HZOE_PS = 15000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    // Cycle counts; the setup cycle already covers one cycle of address-to-write-end
    localparam int unsigned AW_CYC   = ps_to_cyc(T_AW_PS, CLK_PS);
    localparam int unsigned PWE_CYC  = umax(1, umax(umax(ps_to_cyc(T_PWE_PS, CLK_PS),
                                                         ps_to_cyc(T_SD_PS, CLK_PS)),
                                                    (AW_CYC > 1) ? AW_CYC - 1 : 1));
    localparam int unsigned HOLD_CYC = umax(1, ps_to_cyc(T_HOLD_PS, CLK_PS));
    localparam int unsigned TA_CYC   = umax(1, ps_to_cyc(T_HZOE_PS, CLK_PS));
    localparam int unsigned RD_CYC   = umax(1, umax(ps_to_cyc(T_AA_PS, CLK_PS),
                                                    ps_to_cyc(T_RC_PS, CLK_PS)));
    localparam int unsigned WC_CYC   = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned W_TOTAL  = 1 + PWE_CYC + HOLD_CYC;
    localparam int unsigned GAP_CYC  = (WC_CYC > W_TOTAL) ? WC_CYC - W_TOTAL : 0;

    logic             accept;
    logic             timer_load;
    logic [CNT_W-1:0] timer_val;
    logic             timer_done;
    logic             capture;

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .TA_CYC   (TA_CYC),
        .PWE_CYC  (PWE_CYC),
        .HOLD_CYC (HOLD_CYC),
        .RD_CYC   (RD_CYC),
        .GAP_CYC  (GAP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .timer_done (timer_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .capture    (capture),
        .cs_n       (mem_cs_n),
        .we_n       (mem_we_n),
        .oe_n       (mem_oe_n),
        .dq_oe      (mem_dq_oe)
    );

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_rdcap (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .dq_in    (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // Address and write byte held for the whole access
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= req_addr;
            mem_dq_out <= req_wdata;
        end
    end

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr)); // R8
    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out)); // R3

endmodule

// File: tb/sram_seq_bench.sv
module sram_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int tests  = 0;
    int failed = 0;

    always #10 clk = ~clk;

    sram_seq u_sram_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // Memory model (low address byte selects the cell) and independent shadow
    logic [7:0] mem_m  [256];
    logic [7:0] shadow [256];
    initial for (int i = 0; i < 256; i++) begin
        mem_m[i]  = 8'(i) ^ 8'h3C;
        shadow[i] = 8'(i) ^ 8'h3C;
    end
    assign mem_dq_in = (!mem_cs_n && !mem_oe_n && mem_we_n) ? mem_m[mem_addr[7:0]] : 8'h00;

    logic [7:0]  rd_exp_q [$];
    logic [26:0] wr_exp_q [$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input logic [18:0] a, input logic [7:0] d,
                         input int exp_busy, input string req);
        int busy;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        if (wr) begin
            shadow[a[7:0]] = d;
            wr_exp_q.push_back({a, d});
        end else begin
            rd_exp_q.push_back(shadow[a[7:0]]);
        end
        @(negedge clk);
        req_valid = 1'b0;
        busy = 0;
        while (!req_ready) begin
            busy++;
            @(negedge clk);
        end
        check(busy == exp_busy, req, busy, exp_busy);
    endtask

    // Monitors
    bit prev_we_n = 1'b1, prev_oe_n = 1'b1, prev_dq_oe = 1'b0, prev_cs_n = 1'b1;
    logic [18:0] prev_addr = '0;
    int  we_low = 0;
    int  since_oe = 0;
    bit  oe_pending = 1'b0;
    int  fight_err = 0, addr_err = 0, we_err = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_valid) begin
                if (rd_exp_q.size() == 0) begin
                    check(1'b0, "R9 unexpected rd_valid", rd_data, 0);
                end else begin
                    logic [7:0] e;
                    e = rd_exp_q.pop_front();
                    check(rd_data == e, "R4/R9 read data", rd_data, e);
                end
            end
            if (mem_dq_oe && !mem_oe_n) fight_err++;
            if (!mem_we_n && (mem_cs_n || !mem_oe_n)) we_err++;
            if (!mem_cs_n && !prev_cs_n && mem_addr != prev_addr) addr_err++;
            if (!mem_we_n) we_low++;
            if (mem_we_n && !prev_we_n) begin
                logic [26:0] w;
                check(we_low == 2, "R2 write pulse width", we_low, 2);
                we_low = 0;
                if (!mem_cs_n) mem_m[mem_addr[7:0]] = mem_dq_out;
                w = (wr_exp_q.size() != 0) ? wr_exp_q.pop_front() : '0;
                check(mem_dq_oe && {mem_addr, mem_dq_out} == w, "R3 write address/data at end",
                      {mem_addr, mem_dq_out}, w);
            end
            if (mem_dq_oe && !prev_dq_oe && oe_pending) begin
                check(since_oe + 1 >= 2, "R6 turnaround", since_oe + 1, 2);
                oe_pending = 1'b0;
            end
            if (mem_oe_n && !prev_oe_n) begin
                since_oe = 0;
                oe_pending = 1'b1;
            end else begin
                since_oe++;
            end
        end
        prev_we_n = mem_we_n; prev_oe_n = mem_oe_n; prev_dq_oe = mem_dq_oe;
        prev_cs_n = mem_cs_n; prev_addr = mem_addr;
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, failed);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!req_ready, "R1 ready low in reset", req_ready, 0);
        check({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes in reset",
              {mem_cs_n, mem_we_n, mem_oe_n}, 7);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check(!mem_dq_oe && !rd_valid, "R1 dq_oe/rd_valid idle", {mem_dq_oe, rd_valid}, 0);
        check({mem_cs_n, mem_we_n, mem_oe_n} == 3'b111, "R1 strobes idle",
              {mem_cs_n, mem_we_n, mem_oe_n}, 7);

        issue(1'b1, 19'h00012, 8'h5A, 4, "R7 write busy");
        issue(1'b1, 19'h7FF34, 8'hA5, 4, "R7 write busy back-to-back");
        issue(1'b0, 19'h00012, 8'h00, 2, "R7 read busy");
        issue(1'b0, 19'h7FF34, 8'h00, 2, "R9 read accepted with rd_valid");
        issue(1'b1, 19'h00056, 8'hC3, 5, "R6 write after read busy");
        issue(1'b0, 19'h40078, 8'h00, 2, "R4 read of untouched cell");
        issue(1'b0, 19'h00056, 8'h00, 2, "R4 read back");
        issue(1'b1, 19'h1209A, 8'h00, 5, "R7 write after read");
        issue(1'b1, 19'h1209B, 8'hFF, 4, "R7 write after write");
        issue(1'b0, 19'h1209A, 8'h00, 2, "R4 read zero byte");
        issue(1'b0, 19'h1209B, 8'h00, 2, "R4 read ff byte");
        repeat (4) @(negedge clk);

        check(rd_exp_q.size() == 0, "R9 all reads returned", rd_exp_q.size(), 0);
        check(wr_exp_q.size() == 0, "R3 all writes landed", wr_exp_q.size(), 0);
        check(fight_err == 0, "R5 no bus fight", fight_err, 0);
        check(we_err == 0, "R2 we only with cs low, oe high", we_err, 0);
        check(addr_err == 0, "R8 address stable while selected", addr_err, 0);
        finish_run();
    end

endmodule